// File: doc/BRIEF.md
# Board Bank Extension Decoder

This block sits beside a five-bit serially loaded bank controller and widens what a board can address. It watches the controller's mode register and its two character-bank registers, and reuses register bits that the character path leaves idle. Depending on a static board-type input, those bits become a sixth PRG ROM address line that picks a 256 KiB half of a 512 KiB ROM, a select for an 8 KiB page of work RAM, or, on small boards without character ROM, a work-RAM disable.

Which character register supplies the reused bits depends on the character mode. In 8 KiB mode the low register is always the source. In 4 KiB mode the source follows the pattern-table half being fetched, so the outputs can change during rendering. The block also decodes the CPU address and produces the work-RAM chip enable for the 8 KiB window at $6000-$7FFF. All outputs are registered and show the inputs sampled at the previous clock edge.

Top module: `bank_ext_unit`

## Requirements
- R1: While reset is held, rom_blk_o, ram_page_o and ram_ce_o are 0. After reset, every output shows the inputs sampled at the previous rising clock edge.
- R2: When bit 4 of mode_reg is 0 (8 KiB character mode), the source register is chr_bank0. chr_bank1 and ppu_a12 have no effect on any output.
- R3: When bit 4 of mode_reg is 1 (4 KiB character mode), the source register is chr_bank0 while ppu_a12 is 0 and chr_bank1 while ppu_a12 is 1.
- R4: With board_sel = 1 (512 KiB ROM board), rom_blk_o equals bit 4 of the source register and ram_page_o is 0. This ROM block bit applies to every PRG window, the fixed ones included.
- R5: With board_sel = 2 (16 KiB RAM board), ram_page_o[1] is 0 and rom_blk_o is 0. ram_page_o[0] is bit 4 of the source register in 4 KiB mode and bit 3 of chr_bank0 in 8 KiB mode.
- R6: With board_sel = 3 (32 KiB RAM board), rom_blk_o is bit 4 of the source register and ram_page_o is bits 3:2 of the source register.
- R7: With board_sel = 0 (standard board), rom_blk_o and ram_page_o are 0.
- R8: ram_ce_o is 1 only when cpu_addr lies in $6000-$7FFF and no disable condition holds.
- R9: When ram_off (the disable bit of the PRG register) is 1, ram_ce_o is 0.
- R10: With board_sel = 0 and chr_is_ram = 1, bit 4 of the source register set to 1 forces ram_ce_o to 0. For any other board_sel, chr_is_ram has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| board_sel | input | 2 | Static board type: 0 standard, 1 512 KiB ROM, 2 16 KiB RAM, 3 32 KiB RAM |
| chr_is_ram | input | 1 | Board carries character RAM instead of character ROM |
| mode_reg | input | 5 | Controller mode register; bit 4 selects 4 KiB character mode |
| chr_bank0 | input | 5 | Low character bank register |
| chr_bank1 | input | 5 | High character bank register |
| ram_off | input | 1 | Work-RAM disable bit from the PRG register |
| ppu_a12 | input | 1 | Pattern-table half currently fetched |
| cpu_addr | input | 16 | CPU address |
| rom_blk_o | output | 1 | Extra PRG ROM address bit (256 KiB half) |
| ram_page_o | output | 2 | 8 KiB work-RAM page select |
| ram_ce_o | output | 1 | Work-RAM chip enable |

## Verification
The bench uses the default parameters: a 16-bit CPU address, an 8 KiB window based at $6000, and the RAM disable bit present. With these values it can reach the window edges at $5FFF, $6000, $7FFF and $8000, and can check the disable bit's gating of the chip enable. For each board type it runs both character modes and toggles the pattern-half line between vectors that differ only in which register holds the reused bits. This shows whether the source switches or stays fixed.

// File: rtl/bank_ext_pkg.sv
package bank_ext_pkg;

   typedef enum logic [1:0] {
      BRD_PLAIN   = 2'd0,
      BRD_WIDEROM = 2'd1,
      BRD_RAM16   = 2'd2,
      BRD_RAM32   = 2'd3
   } board_e;

   localparam int MIN_BANK_W = 5;
   localparam int BLK_BIT    = 4;
   localparam int PG_HI_BIT  = 3;
   localparam int PG_LO_BIT  = 2;
   localparam int PG_W       = 2;

   typedef struct packed {
      logic            rom_blk;
      logic [PG_W-1:0] ram_pg;
      logic            ram_kill;
   } ext_sel_t;

endpackage

// File: rtl/bx_chr_source.sv
module bx_chr_source #(
   parameter int BANK_W = 5
) (
   input  logic              mode4k,
   input  logic              a12,
   input  logic [BANK_W-1:0] bank_lo,
   input  logic [BANK_W-1:0] bank_hi,
   output logic [BANK_W-1:0] src
);
   // 8 KiB mode: low register only. 4 KiB mode: register of the fetched half.
   always_comb begin
      if (mode4k && a12)
         src = bank_hi;
      else
         src = bank_lo;
   end
endmodule

// File: rtl/bx_steal_decode.sv
module bx_steal_decode
   import bank_ext_pkg::*;
#(
   parameter int BANK_W = 5
) (
   input  board_e            board,
   input  logic              mode4k,
   input  logic              chr_is_ram,
   input  logic [BANK_W-1:0] src,
   input  logic [BANK_W-1:0] bank_lo,
   output ext_sel_t          sel
);
   always_comb begin
      sel = '0;
      unique case (board)
         BRD_PLAIN: begin
            sel.ram_kill = chr_is_ram & src[BLK_BIT];
         end
         BRD_WIDEROM: begin
            sel.rom_blk = src[BLK_BIT];
         end
         BRD_RAM16: begin
            sel.ram_pg[0] = mode4k ? src[BLK_BIT] : bank_lo[PG_HI_BIT];
         end
         BRD_RAM32: begin
            sel.rom_blk = src[BLK_BIT];
            sel.ram_pg  = src[PG_HI_BIT:PG_LO_BIT];
         end
         default: sel = '0;
      endcase
   end
endmodule

// File: rtl/bx_ram_window.sv
module bx_ram_window #(
   parameter int          ADDR_W   = 16,
   parameter int          WIN_LOG2 = 13,
   parameter logic [31:0] WIN_BASE = 32'h6000,
   parameter bit          HAS_OFF  = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              ram_off,
   input  logic              kill,
   output logic              ce
);
   localparam int TAG_W = ADDR_W - WIN_LOG2;
   localparam logic [ADDR_W-1:0] BASE_A = WIN_BASE[ADDR_W-1:0];
   localparam logic [TAG_W-1:0]  TAG    = BASE_A[ADDR_W-1:WIN_LOG2];

   logic hit;
   logic off_eff;

   assign hit = (addr[ADDR_W-1:WIN_LOG2] == TAG);

   generate
      if (HAS_OFF) begin : g_off
         assign off_eff = ram_off;
      end else begin : g_nooff
         assign off_eff = 1'b0;
      end
   endgenerate

   assign ce = hit & ~off_eff & ~kill;
endmodule

// File: rtl/bank_ext_unit.sv
module bank_ext_unit
   import bank_ext_pkg::*;
#(
   parameter int          BANK_W   = 5,
   parameter int          MODE_W   = 5,
   parameter int          ADDR_W   = 16,
   parameter int          WIN_LOG2 = 13,
   parameter logic [31:0] WIN_BASE = 32'h6000,
   parameter bit          HAS_OFF  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        board_sel,
   input  logic              chr_is_ram,
   input  logic [MODE_W-1:0] mode_reg,
   input  logic [BANK_W-1:0] chr_bank0,
   input  logic [BANK_W-1:0] chr_bank1,
   input  logic              ram_off,
   input  logic              ppu_a12,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              rom_blk_o,
   output logic [PG_W-1:0]   ram_page_o,
   output logic              ram_ce_o
);
   localparam int CHR4K_BIT = 4;
   localparam int TAG_W     = ADDR_W - WIN_LOG2;
   localparam logic [ADDR_W-1:0] BASE_A = WIN_BASE[ADDR_W-1:0];

   generate
      if (BANK_W < MIN_BANK_W) begin : g_bad_bank
         $error("BANK_W must be at least 5");
      end
      if (MODE_W <= CHR4K_BIT) begin : g_bad_mode
         $error("MODE_W must cover the character mode bit");
      end
      if (WIN_LOG2 >= ADDR_W) begin : g_bad_win
         $error("RAM window must be smaller than the address space");
      end
   endgenerate

   board_e              board;
   logic                mode4k;
   logic [BANK_W-1:0]   src;
   ext_sel_t            sel;
   logic                ce_d;

   assign board  = board_e'(board_sel);
   assign mode4k = mode_reg[CHR4K_BIT];

   bx_chr_source #(.BANK_W(BANK_W)) u_src (
      .mode4k (mode4k),
      .a12    (ppu_a12),
      .bank_lo(chr_bank0),
      .bank_hi(chr_bank1),
      .src    (src)
   );

   bx_steal_decode #(.BANK_W(BANK_W)) u_dec (
      .board     (board),
      .mode4k    (mode4k),
      .chr_is_ram(chr_is_ram),
      .src       (src),
      .bank_lo   (chr_bank0),
      .sel       (sel)
   );

   bx_ram_window #(
      .ADDR_W  (ADDR_W),
      .WIN_LOG2(WIN_LOG2),
      .WIN_BASE(WIN_BASE),
      .HAS_OFF (HAS_OFF)
   ) u_win (
      .addr   (cpu_addr),
      .ram_off(ram_off),
      .kill   (sel.ram_kill),
      .ce     (ce_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rom_blk_o  <= 1'b0;
         ram_page_o <= '0;
         ram_ce_o   <= 1'b0;
      end else begin
         rom_blk_o  <= sel.rom_blk;
         ram_page_o <= sel.ram_pg;
         ram_ce_o   <= ce_d;
      end
   end

   // R7
   plain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (board_sel == 2'd0) |=> (!rom_blk_o && ram_page_o == '0));

   // R8
   win_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[ADDR_W-1:WIN_LOG2] != BASE_A[ADDR_W-1:WIN_LOG2]) |=> !ram_ce_o);

   // R5
   ram16_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (board_sel == 2'd2) |=> (!ram_page_o[1] && !rom_blk_o));

   // R2
   wide8k_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (board_sel == 2'd1 && !mode_reg[CHR4K_BIT]) |=> (rom_blk_o == $past(chr_bank0[4])));

   // R3
   wide4k_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (board_sel == 2'd1 && mode_reg[CHR4K_BIT] && ppu_a12) |=> (rom_blk_o == $past(chr_bank1[4])));

   generate
      if (HAS_OFF) begin : g_off_chk
         // R9
         off_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ram_off |=> !ram_ce_o);
      end
   endgenerate
endmodule

// File: tb/sim_bank_ext_unit.sv
`timescale 1ns/1ps
module sim_bank_ext_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  board_sel = '0;
   logic        chr_is_ram = 1'b0;
   logic [4:0]  mode_reg = '0;
   logic [4:0]  chr_bank0 = '0;
   logic [4:0]  chr_bank1 = '0;
   logic        ram_off = 1'b0;
   logic        ppu_a12 = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        rom_blk_o;
   logic [1:0]  ram_page_o;
   logic        ram_ce_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   typedef struct {
      logic [3:0] exp;
      string      tag;
   } item_t;
   item_t sb[$];

   always #2 clk = ~clk;

   bank_ext_unit u0 (
      .clk(clk), .rst_n(rst_n), .board_sel(board_sel), .chr_is_ram(chr_is_ram),
      .mode_reg(mode_reg), .chr_bank0(chr_bank0), .chr_bank1(chr_bank1),
      .ram_off(ram_off), .ppu_a12(ppu_a12), .cpu_addr(cpu_addr),
      .rom_blk_o(rom_blk_o), .ram_page_o(ram_page_o), .ram_ce_o(ram_ce_o)
   );

   // Expected {rom_blk, page[1:0], ce} from the requirements
   function automatic logic [3:0] model(logic [1:0] b, logic cr, logic m4, logic [4:0] b0,
                                        logic [4:0] b1, logic off, logic a12, logic [15:0] a);
      logic [4:0] s;
      logic       blk, kill, ce;
      logic [1:0] pg;
      s    = (m4 && a12) ? b1 : b0;
      blk  = (b == 2'd1 || b == 2'd3) ? s[4] : 1'b0;
      pg   = (b == 2'd2) ? {1'b0, (m4 ? s[4] : b0[3])} : (b == 2'd3) ? s[3:2] : 2'b00;
      kill = (b == 2'd0) && cr && s[4];
      ce   = (a >= 16'h6000 && a <= 16'h7FFF) && !off && !kill;
      return {blk, pg, ce};
   endfunction

   task automatic apply(input logic [1:0] b, input logic cr, input logic m4,
                        input logic [4:0] b0, input logic [4:0] b1, input logic off,
                        input logic a12, input logic [15:0] a, input string tag);
      item_t it;
      @(negedge clk);
      board_sel = b; chr_is_ram = cr; mode_reg = {m4, 4'b0110};
      chr_bank0 = b0; chr_bank1 = b1; ram_off = off; ppu_a12 = a12; cpu_addr = a;
      it.exp = model(b, cr, m4, b0, b1, off, a12, a);
      it.tag = tag;
      sb.push_back(it);
   endtask

   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         item_t it;
         logic [3:0] act;
         it  = sb.pop_front();
         act = {rom_blk_o, ram_page_o, ram_ce_o};
         n_vec++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", it.tag, act, it.exp);
         end
      end
   end

   initial begin
      #40000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state with busy inputs
      board_sel = 2'd3; chr_bank0 = 5'h1F; cpu_addr = 16'h6000;
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_vec++;
      if ({rom_blk_o, ram_page_o, ram_ce_o} !== 4'b0000) begin
         n_bad++;
         $display("FAIL R1: got %b expected 0000", {rom_blk_o, ram_page_o, ram_ce_o});
      end
      rst_n = 1'b1;

      // R7 standard board
      apply(2'd0, 0, 0, 5'h1F, 5'h1F, 0, 0, 16'h6000, "R7 plain 8k");
      apply(2'd0, 0, 1, 5'h1F, 5'h1F, 0, 1, 16'h7000, "R7 plain 4k");
      // R4 / R2: 8K mode, bank1 and a12 ignored
      apply(2'd1, 0, 0, 5'h10, 5'h00, 0, 0, 16'h6000, "R4 wide blk set");
      apply(2'd1, 0, 0, 5'h10, 5'h00, 0, 1, 16'h6000, "R2 a12 ignored");
      apply(2'd1, 0, 0, 5'h00, 5'h1F, 0, 1, 16'h6000, "R2 bank1 ignored");
      // R3: 4K mode switching with a12
      apply(2'd1, 0, 1, 5'h00, 5'h10, 0, 0, 16'h6000, "R3 low half");
      apply(2'd1, 0, 1, 5'h00, 5'h10, 0, 1, 16'h6000, "R3 high half");
      apply(2'd1, 0, 1, 5'h10, 5'h00, 0, 1, 16'h6000, "R3 high half clear");
      // R5
      apply(2'd2, 0, 0, 5'h08, 5'h00, 0, 0, 16'h6000, "R5 8k bit3");
      apply(2'd2, 0, 0, 5'h17, 5'h1F, 0, 1, 16'h6000, "R5 8k bit4 unused");
      apply(2'd2, 0, 1, 5'h00, 5'h10, 0, 1, 16'h6000, "R5 4k high reg");
      apply(2'd2, 0, 1, 5'h0F, 5'h10, 0, 0, 16'h6000, "R5 4k low reg");
      // R6
      apply(2'd3, 0, 0, 5'h1C, 5'h00, 0, 0, 16'h6000, "R6 8k full");
      apply(2'd3, 0, 0, 5'h08, 5'h14, 0, 1, 16'h6000, "R6 8k pg2");
      apply(2'd3, 0, 1, 5'h00, 5'h14, 0, 1, 16'h6000, "R6 4k high");
      // R8 window edges
      apply(2'd0, 0, 0, 5'h00, 5'h00, 0, 0, 16'h5FFF, "R8 below");
      apply(2'd0, 0, 0, 5'h00, 5'h00, 0, 0, 16'h7FFF, "R8 top");
      apply(2'd0, 0, 0, 5'h00, 5'h00, 0, 0, 16'h8000, "R8 above");
      apply(2'd0, 0, 0, 5'h00, 5'h00, 0, 0, 16'hE000, "R8 far");
      // R9
      apply(2'd0, 0, 0, 5'h00, 5'h00, 1, 0, 16'h6800, "R9 off");
      apply(2'd3, 0, 0, 5'h00, 5'h00, 1, 0, 16'h7800, "R9 off ram32");
      // R10
      apply(2'd0, 1, 0, 5'h10, 5'h00, 0, 0, 16'h6000, "R10 kill 8k");
      apply(2'd0, 1, 1, 5'h00, 5'h10, 0, 0, 16'h6000, "R10 4k low no kill");
      apply(2'd0, 1, 1, 5'h00, 5'h10, 0, 1, 16'h6000, "R10 4k high kill");
      apply(2'd1, 1, 0, 5'h10, 5'h00, 0, 0, 16'h6000, "R10 wide no effect");
      apply(2'd2, 1, 1, 5'h10, 5'h10, 0, 1, 16'h6000, "R10 ram16 no effect");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule